// File: doc/BRIEF.md
# Converter Power-State Controller

This block picks the operating state of a data converter's digital back end: full operation, a light power-down or a deep power-down. By default the state follows a three-level strap pin, which arrives here already decoded into a two-bit code. The serial control port can override the strap by delivering a decoded register write that carries an enable bit and a two-bit mode field. Clearing the enable bit hands control back to the strap.

The block drives four sets of outputs. The first is the active mode. The second is a per-block power-down vector, and the deep state shuts down a superset of the blocks that the light state shuts down. The third is a registered output-enable that tri-states the data, clock-out and over-range pads. The last is a ready flag. When the block returns to full operation, ready and the output-enables stay low for a settling count of input clocks. That count is longer when a clock-stopped indication was seen during the low-power period, because the delay-locked loop then has to relock.

Top module: `pwr_state_ctrl`

## Requirements
- R1: The strap code decodes as follows: 00 selects run, 01 selects deep power-down and 10 selects light power-down. Code 11 is treated as run. `mode_o` reports run as 00, deep as 01 and light as 10.
- R2: With no override active, `mode_o` takes the decoded strap value sampled at each rising clock edge, so it updates at that same edge.
- R3: A write strobe with the enable bit at 1 is captured at one edge. From the following edge, `mode_o` follows the written mode field, which decodes like R1 with 11 meaning run, and the strap is ignored.
- R4: A write strobe with the enable bit at 0 returns control to the strap from the edge after the write is captured.
- R5: In either low-power mode, `ready` is 0 and every bit of `out_en` is 0. Both change at the same edge as `mode_o`.
- R6: `pd_en` equals NAP_MASK in light mode, SLEEP_MASK in deep mode and all zeros in run mode, updated at the same edge as `mode_o`.
- R7: When `mode_o` changes from low-power to run with no clock-stop seen, `ready` and `out_en` stay 0 for WAKE_CYC cycles and then go high together.
- R8: If `clk_stopped` is 1 at any edge while the block is in low-power, the next wake lasts RELOCK_CYC cycles instead of WAKE_CYC.
- R9: During reset, `mode_o` is run and `ready`, `out_en` and `pd_en` are 0. After reset, with the strap at run, `ready` rises after WAKE_CYC cycles.
- R10: Going back to low-power during a wake cancels it. The next wake starts a full count again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_code | input | 2 | Decoded three-level strap code |
| ovr_wr | input | 1 | Override register write strobe |
| ovr_en | input | 1 | Override enable bit of the write |
| ovr_mode | input | 2 | Override mode field of the write |
| clk_stopped | input | 1 | Indicates that the input clock stopped |
| mode_o | output | 2 | Active mode |
| pd_en | output | NUM_BLK | Per-block power-down enables |
| out_en | output | OE_W | Output-enables for the pad groups (1 means drive) |
| ready | output | 1 | Wake-up settling is complete |

## Verification
The bench builds the block with WAKE_CYC = 5 and RELOCK_CYC = 12. These short counts bring both wake lengths, a wake cancelled part-way and the end of the count all within a few dozen cycles. NAP_MASK = 0011 and SLEEP_MASK = 1111 make the two low-power states give different power-down vectors. Three output-enable bits show that all pad groups switch together.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;

   typedef enum logic [1:0] {
      PM_RUN   = 2'b00,
      PM_DEEP  = 2'b01,
      PM_LIGHT = 2'b10
   } pm_mode_t;

   // Strap and override fields share one code space; 11 maps to run.
   function automatic pm_mode_t pm_decode(input logic [1:0] code);
      case (code)
         2'b01:   pm_decode = PM_DEEP;
         2'b10:   pm_decode = PM_LIGHT;
         default: pm_decode = PM_RUN;
      endcase
   endfunction

endpackage

// File: rtl/pwr_mode_sel.sv
module pwr_mode_sel
   import pwr_state_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] strap_code,
   input  logic       wr_stb,
   input  logic       wr_en,
   input  logic [1:0] wr_mode,
   output pm_mode_t   req_mode
);
   logic       ovr_on_q;
   logic [1:0] ovr_code_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr_on_q   <= 1'b0;
         ovr_code_q <= 2'b00;
      end else if (wr_stb) begin
         ovr_on_q   <= wr_en;
         ovr_code_q <= wr_mode;
      end
   end

   always_comb begin
      req_mode = ovr_on_q ? pm_decode(ovr_code_q) : pm_decode(strap_code);
   end
endmodule

// File: rtl/pwr_wake_timer.sv
module pwr_wake_timer #(
   parameter int WAKE_CYC   = 32,
   parameter int RELOCK_CYC = 1024,
   localparam int CNT_W     = $clog2(RELOCK_CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cur_lp,
   input  logic nxt_lp,
   input  logic clk_stopped,
   output logic settle_nxt
);
   localparam logic [CNT_W-1:0] WAKE_LD   = CNT_W'(WAKE_CYC);
   localparam logic [CNT_W-1:0] RELOCK_LD = CNT_W'(RELOCK_CYC);

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             stop_q, stop_d;

   always_comb begin
      if (nxt_lp)
         cnt_d = '0;
      else if (cur_lp)
         cnt_d = stop_q ? RELOCK_LD : WAKE_LD;
      else if (cnt_q != '0)
         cnt_d = cnt_q - 1'b1;
      else
         cnt_d = '0;
      stop_d     = cur_lp ? (stop_q | clk_stopped) : 1'b0;
      settle_nxt = !nxt_lp && (cnt_d == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= WAKE_LD;
         stop_q <= 1'b0;
      end else begin
         cnt_q  <= cnt_d;
         stop_q <= stop_d;
      end
   end
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
   import pwr_state_pkg::*;
#(
   parameter int               NUM_BLK    = 4,
   parameter int               OE_W       = 3,
   parameter int               WAKE_CYC   = 32,
   parameter int               RELOCK_CYC = 1024,
   parameter logic [NUM_BLK-1:0] NAP_MASK   = 4'b0011,
   parameter logic [NUM_BLK-1:0] SLEEP_MASK = 4'b1111
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         strap_code,
   input  logic               ovr_wr,
   input  logic               ovr_en,
   input  logic [1:0]         ovr_mode,
   input  logic               clk_stopped,
   output logic [1:0]         mode_o,
   output logic [NUM_BLK-1:0] pd_en,
   output logic [OE_W-1:0]    out_en,
   output logic               ready
);
   if (WAKE_CYC < 1) begin : g_bad_wake
      $error("WAKE_CYC must be at least 1");
   end
   if (RELOCK_CYC < WAKE_CYC) begin : g_bad_relock
      $error("RELOCK_CYC must not be below WAKE_CYC");
   end
   if ((NAP_MASK & ~SLEEP_MASK) != '0) begin : g_bad_mask
      $error("NAP_MASK must be a subset of SLEEP_MASK");
   end

   pm_mode_t mode_q, req_mode;
   logic     settle_nxt;
   logic     ready_q;
   logic [OE_W-1:0]    oe_q;
   logic [NUM_BLK-1:0] pd_q;

   pwr_mode_sel u_sel (
      .clk        (clk),
      .rst_n      (rst_n),
      .strap_code (strap_code),
      .wr_stb     (ovr_wr),
      .wr_en      (ovr_en),
      .wr_mode    (ovr_mode),
      .req_mode   (req_mode)
   );

   pwr_wake_timer #(
      .WAKE_CYC   (WAKE_CYC),
      .RELOCK_CYC (RELOCK_CYC)
   ) u_tmr (
      .clk         (clk),
      .rst_n       (rst_n),
      .cur_lp      (mode_q != PM_RUN),
      .nxt_lp      (req_mode != PM_RUN),
      .clk_stopped (clk_stopped),
      .settle_nxt  (settle_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= PM_RUN;
         ready_q <= 1'b0;
      end else begin
         mode_q  <= req_mode;
         ready_q <= settle_nxt;
      end
   end

   // One flop per pad group so each enable leaves a register directly.
   for (genvar g = 0; g < OE_W; g++) begin : g_oe
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) oe_q[g] <= 1'b0;
         else        oe_q[g] <= settle_nxt;
      end
   end

   for (genvar b = 0; b < NUM_BLK; b++) begin : g_pd
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pd_q[b] <= 1'b0;
         else
            pd_q[b] <= (req_mode == PM_LIGHT) ? NAP_MASK[b] :
                       (req_mode == PM_DEEP)  ? SLEEP_MASK[b] : 1'b0;
      end
   end

   assign mode_o = mode_q;
   assign ready  = ready_q;
   assign out_en = oe_q;
   assign pd_en  = pd_q;
endmodule

// File: rtl/pwr_state_chk.sv
module pwr_state_chk #(
   parameter int               NUM_BLK    = 4,
   parameter int               OE_W       = 3,
   parameter logic [NUM_BLK-1:0] NAP_MASK   = 4'b0011,
   parameter logic [NUM_BLK-1:0] SLEEP_MASK = 4'b1111
) (
   input logic               clk,
   input logic               rst_n,
   input logic [1:0]         mode_o,
   input logic [NUM_BLK-1:0] pd_en,
   input logic [OE_W-1:0]    out_en,
   input logic               ready
);
   a_r5_lowpower_tristate: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o != 2'b00) |-> (!ready && out_en == '0));

   a_r6_light_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'b10) |-> (pd_en == NAP_MASK));

   a_r6_deep_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'b01) |-> (pd_en == SLEEP_MASK));

   a_r6_run_no_pd: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'b00) |-> (pd_en == '0));

   a_r7_wake_starts_low: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'b00 && $past(mode_o) != 2'b00) |-> !ready);

   a_r7_oe_tracks_ready: assert property (@(posedge clk) disable iff (!rst_n)
      out_en == {OE_W{ready}});

   a_r10_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'b00 && $past(mode_o) == 2'b00 && $past(ready)) |-> ready);
endmodule

bind pwr_state_ctrl pwr_state_chk #(
   .NUM_BLK    (NUM_BLK),
   .OE_W       (OE_W),
   .NAP_MASK   (NAP_MASK),
   .SLEEP_MASK (SLEEP_MASK)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .mode_o (mode_o),
   .pd_en  (pd_en),
   .out_en (out_en),
   .ready  (ready)
);

// File: tb/sim_pwr_state_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_state_ctrl;
   localparam int NB = 4;
   localparam int OW = 3;
   localparam int WK = 5;
   localparam int RL = 12;
   localparam logic [NB-1:0] NMASK = 4'b0011;
   localparam logic [NB-1:0] SMASK = 4'b1111;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] strap_code = 2'b00;
   logic ovr_wr = 1'b0, ovr_en = 1'b0;
   logic [1:0] ovr_mode = 2'b00;
   logic clk_stopped = 1'b0;
   logic [1:0] mode_o;
   logic [NB-1:0] pd_en;
   logic [OW-1:0] out_en;
   logic ready;

   always #10 clk = ~clk;

   pwr_state_ctrl #(.NUM_BLK(NB), .OE_W(OW), .WAKE_CYC(WK), .RELOCK_CYC(RL),
                    .NAP_MASK(NMASK), .SLEEP_MASK(SMASK)) u0 (
      .clk(clk), .rst_n(rst_n), .strap_code(strap_code), .ovr_wr(ovr_wr),
      .ovr_en(ovr_en), .ovr_mode(ovr_mode), .clk_stopped(clk_stopped),
      .mode_o(mode_o), .pd_en(pd_en), .out_en(out_en), .ready(ready));

   int vec = 0, bad = 0;
   bit done = 0;
   string tag = "R9";

   // behavioural reference state
   int m_mode = 0, m_cnt = WK, m_ovr_on = 0, m_ovr_md = 0;
   bit m_stop = 0, m_rdy = 0;

   function automatic int dec(int c);
      return (c == 1) ? 1 : (c == 2) ? 2 : 0;
   endfunction

   task automatic model_step();
      int want = (m_ovr_on != 0) ? dec(m_ovr_md) : dec(int'(strap_code));
      int ncnt;
      bit nstop;
      if (want != 0)       ncnt = 0;
      else if (m_mode != 0) ncnt = m_stop ? RL : WK;
      else                 ncnt = (m_cnt > 0) ? m_cnt - 1 : 0;
      nstop = (m_mode == 0) ? 1'b0 : (m_stop | clk_stopped);
      if (ovr_wr) begin
         m_ovr_on = int'(ovr_en);
         m_ovr_md = int'(ovr_mode);
      end
      m_mode = want; m_cnt = ncnt; m_stop = nstop;
      m_rdy  = (want == 0 && ncnt == 0);
   endtask

   task automatic compare();
      logic [NB-1:0] epd = (m_mode == 2) ? NMASK : (m_mode == 1) ? SMASK : '0;
      logic [OW-1:0] eoe = m_rdy ? '1 : '0;
      vec++;
      if (mode_o !== 2'(m_mode) || ready !== m_rdy || out_en !== eoe || pd_en !== epd) begin
         bad++;
         $display("FAIL %s: mode=%0d ready=%0d oe=%b pd=%b expected mode=%0d ready=%0d oe=%b pd=%b",
                  tag, mode_o, ready, out_en, pd_en, m_mode, m_rdy, eoe, epd);
      end
   endtask

   task automatic cyc(int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         model_step();
         @(negedge clk);
         compare();
         ovr_wr = 1'b0;
         clk_stopped = 1'b0;
      end
   endtask

   task automatic wr(bit en, logic [1:0] md);
      ovr_wr = 1'b1; ovr_en = en; ovr_mode = md;
      cyc(1);
   endtask

   initial begin
      // R9: outputs held at reset values while reset is low
      #5;
      compare();
      @(negedge clk);
      compare();
      rst_n = 1'b1;
      tag = "R9"; cyc(8);
      tag = "R1 R2 R5 R6 deep"; strap_code = 2'b01; cyc(4);
      tag = "R1 R2 R5 R6 light"; strap_code = 2'b10; cyc(4);
      tag = "R1 R7 code11 wake"; strap_code = 2'b11; cyc(8);
      tag = "R8 relock"; strap_code = 2'b01; cyc(2);
      clk_stopped = 1'b1; cyc(1);
      cyc(2);
      strap_code = 2'b00; cyc(15);
      tag = "R7 after relock"; strap_code = 2'b10; cyc(2);
      strap_code = 2'b00; cyc(8);
      tag = "R3 override light"; wr(1'b1, 2'b10); cyc(5);
      tag = "R3 override ignores strap"; strap_code = 2'b01; cyc(3);
      tag = "R3 override code11"; wr(1'b1, 2'b11); cyc(8);
      tag = "R4 release to strap"; wr(1'b0, 2'b00); cyc(4);
      tag = "R10 cancel"; strap_code = 2'b00; cyc(2);
      strap_code = 2'b10; cyc(2);
      strap_code = 2'b00; cyc(8);
      tag = "R10 stop then cancel"; strap_code = 2'b01; clk_stopped = 1'b1; cyc(1);
      strap_code = 2'b00; cyc(3);
      strap_code = 2'b10; cyc(1);
      strap_code = 2'b00; cyc(14);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
         $finish;
      end
   end
endmodule